// File: doc/BRIEF.md
# Match Timer Bank with Snapshot Capture

Three independent 32-bit up-counters sit behind a single-cycle register bus. Each channel has three compare values, a reload value and a reload selector. A channel counts one per clock while its bit in the shared run register is set. Each compare hit sets a sticky status bit. When the hit comes from a selected comparator, the counter is loaded with the reload value on the next edge instead of incrementing.

With a reload value of 0 and a compare value of all ones, a channel runs as a free-running wrap-around counter. The running count is never visible on the bus directly. Software writes a request to the capture register, waits for the busy flag to drop, and reads the latched count of channel 0.

Each channel drives one interrupt line. The line is high while any status bit of that channel is set and enabled. Status bits can be cleared through the status register itself, or through a separate per-channel clear register.

Top module: `mtimer_top`

## Requirements
- R1: After reset every count, status, interrupt-enable, reload selector, run bit, snapshot and busy flag reads 0, every compare register reads 0xFFFFFFFF, every preload reads 0, and `irq_o` is 0.
- R2: Bit c of the run register (word 24, bits [2:0]) makes channel c advance by exactly one per clock. While the bit is clear the count holds, and no status bit of that channel is set.
- R3: Compare register of channel c, comparator k, sits at word c*3+k (words 0..8). A write there changes only that register.
- R4: The reload selector of channel c (word 12+c) is a mask in bits [2:0], with bit k picking comparator k, so the value 1 picks comparator 0. When a running channel's count equals a picked compare value, the next count is that channel's preload (word 9+c). A mask of 0 disables reload.
- R5: A running channel with no reload taken steps from 0xFFFFFFFF to 0.
- R6: Status word 15+c holds one sticky bit per comparator (bit k), set when a running channel's count equals compare k. Writing 1 to a bit clears it, writing 0 leaves it, and a new hit in the same cycle wins over the clear.
- R7: The clear register at word 21+c clears the status bits of channel c whose written bits are 1. It reads as 0.
- R8: `irq_o[c]` is 1 exactly when status and interrupt-enable (word 18+c, bits [2:0]) of channel c share a set bit.
- R9: Writing a value with bit 0 set to word 25 starts a capture. The busy flag (word 26, bit 0) is then 1 for two cycles, and the count of channel 0 held at the end of that window is latched. Until then, reads of word 25 return the previous snapshot.
- R10: A capture write with bit 0 clear, or a capture write while busy, has no effect on busy or on the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 3 | Per-channel interrupt |

## Verification
The bench aims at the reload edge. A counter that reloads one cycle late, or that reloads from the compare value, shows a wrong snapshot against the bench model. It drives the count across 0xFFFFFFFF, where a design that saturates or sets a spurious hit would give a large snapshot. It fires a second capture while the first is busy and a capture with bit 0 clear, where a design that restarts or accepts them would stay busy too long or alter the snapshot. It also clears status while the interrupt enable is toggled, to catch an interrupt that ignores the enable or a clear register that misses bits.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  typedef enum logic [3:0] {
    RG_MATCH, RG_PRE, RG_SEL, RG_STS, RG_IE, RG_ICLR, RG_RUN, RG_SNAP, RG_BUSY, RG_NONE
  } mt_region_e;
endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode import mtimer_pkg::*; #(
  parameter int NUM_CH  = 3,
  parameter int NUM_CMP = 3,
  parameter int ADDR_W  = 6,
  parameter int CH_W    = 2,
  parameter int CMP_W   = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output mt_region_e        region_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [CMP_W-1:0]  cmp_o
);
  localparam int unsigned A_PRE  = NUM_CH * NUM_CMP;
  localparam int unsigned A_SEL  = A_PRE + NUM_CH;
  localparam int unsigned A_STS  = A_SEL + NUM_CH;
  localparam int unsigned A_IE   = A_STS + NUM_CH;
  localparam int unsigned A_ICLR = A_IE + NUM_CH;
  localparam int unsigned A_RUN  = A_ICLR + NUM_CH;
  localparam int unsigned A_SNAP = A_RUN + 1;
  localparam int unsigned A_BUSY = A_SNAP + 1;

  logic [31:0] a;
  assign a = 32'(addr_i);

  always_comb begin
    region_o = RG_NONE;
    ch_o     = '0;
    cmp_o    = '0;
    if (a < A_PRE) begin
      region_o = RG_MATCH;
      ch_o     = CH_W'(a / NUM_CMP);
      cmp_o    = CMP_W'(a % NUM_CMP);
    end else if (a < A_SEL) begin
      region_o = RG_PRE;  ch_o = CH_W'(a - A_PRE);
    end else if (a < A_STS) begin
      region_o = RG_SEL;  ch_o = CH_W'(a - A_SEL);
    end else if (a < A_IE) begin
      region_o = RG_STS;  ch_o = CH_W'(a - A_STS);
    end else if (a < A_ICLR) begin
      region_o = RG_IE;   ch_o = CH_W'(a - A_IE);
    end else if (a < A_RUN) begin
      region_o = RG_ICLR; ch_o = CH_W'(a - A_ICLR);
    end else if (a == A_RUN) begin
      region_o = RG_RUN;
    end else if (a == A_SNAP) begin
      region_o = RG_SNAP;
    end else if (a == A_BUSY) begin
      region_o = RG_BUSY;
    end
  end
endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan #(
  parameter int NUM_CMP = 3,
  parameter int CW      = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             run_i,
  input  logic [CW-1:0]                    wdata_i,
  input  logic [NUM_CMP-1:0]               we_match_i,
  input  logic                             we_pre_i,
  input  logic                             we_sel_i,
  input  logic                             we_ie_i,
  input  logic [NUM_CMP-1:0]               clr_i,
  output logic [CW-1:0]                    cnt_o,
  output logic [NUM_CMP-1:0][CW-1:0]       match_o,
  output logic [CW-1:0]                    pre_o,
  output logic [NUM_CMP-1:0]               sel_o,
  output logic [NUM_CMP-1:0]               ie_o,
  output logic [NUM_CMP-1:0]               sts_o,
  output logic                             irq_o
);
  logic [NUM_CMP-1:0] hit;
  logic               reload;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign hit[k] = run_i && (cnt_o == match_o[k]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            match_o[k] <= '1;
      else if (we_match_i[k]) match_o[k] <= wdata_i;
    end
  end

  assign reload = |(hit & sel_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      pre_o <= '0;
      sel_o <= '0;
      ie_o  <= '0;
      sts_o <= '0;
    end else begin
      if (run_i) cnt_o <= reload ? pre_o : cnt_o + 1'b1;
      if (we_pre_i) pre_o <= wdata_i;
      if (we_sel_i) sel_o <= wdata_i[NUM_CMP-1:0];
      if (we_ie_i)  ie_o  <= wdata_i[NUM_CMP-1:0];
      sts_o <= (sts_o & ~clr_i) | hit;  // new hit wins over clear
    end
  end

  assign irq_o = |(sts_o & ie_o);
endmodule

// File: rtl/mtimer_snap.sv
module mtimer_snap #(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] snap_o,
  output logic          busy_o
);
  localparam int SW = $clog2(SYNC_STAGES + 1);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      snap_o <= '0;
    end else if (left_q != '0) begin
      if (left_q == SW'(1)) snap_o <= cnt_i;
      left_q <= left_q - 1'b1;
    end else if (req_i) begin
      left_q <= SW'(SYNC_STAGES);
    end
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top import mtimer_pkg::*; #(
  parameter int NUM_CH      = 3,
  parameter int NUM_CMP     = 3,
  parameter int CW          = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CW-1:0]     bus_wdata_i,
  output logic [CW-1:0]     bus_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int CH_W  = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1;
  localparam int CMP_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;

  mt_region_e         region;
  logic [CH_W-1:0]    ch;
  logic [CMP_W-1:0]   cmp;
  logic               wr;

  logic [NUM_CH-1:0]                       run_q;
  logic [NUM_CH-1:0][CW-1:0]               cnt_q;
  logic [NUM_CH-1:0][NUM_CMP-1:0][CW-1:0]  match_q;
  logic [NUM_CH-1:0][CW-1:0]               pre_q;
  logic [NUM_CH-1:0][NUM_CMP-1:0]          sel_q;
  logic [NUM_CH-1:0][NUM_CMP-1:0]          ie_q;
  logic [NUM_CH-1:0][NUM_CMP-1:0]          sts_q;
  logic [NUM_CH-1:0][NUM_CMP-1:0]          clr;
  logic [CW-1:0]                           snap_q;
  logic                                    busy;

  assign wr = bus_req_i && bus_we_i;

  mtimer_decode #(
    .NUM_CH(NUM_CH), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .CH_W(CH_W), .CMP_W(CMP_W)
  ) u_dec (
    .addr_i(bus_addr_i), .region_o(region), .ch_o(ch), .cmp_o(cmp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    run_q <= '0;
    else if (wr && region == RG_RUN) run_q <= bus_wdata_i[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_ch;
    logic [NUM_CMP-1:0] we_match;
    assign sel_ch = wr && (ch == CH_W'(c));
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_wm
      assign we_match[k] = sel_ch && (region == RG_MATCH) && (cmp == CMP_W'(k));
    end
    assign clr[c] = (sel_ch && (region == RG_STS || region == RG_ICLR))
                    ? bus_wdata_i[NUM_CMP-1:0] : '0;

    mtimer_chan #(.NUM_CMP(NUM_CMP), .CW(CW)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q[c]), .wdata_i(bus_wdata_i),
      .we_match_i(we_match),
      .we_pre_i(sel_ch && region == RG_PRE),
      .we_sel_i(sel_ch && region == RG_SEL),
      .we_ie_i(sel_ch && region == RG_IE),
      .clr_i(clr[c]),
      .cnt_o(cnt_q[c]), .match_o(match_q[c]), .pre_o(pre_q[c]),
      .sel_o(sel_q[c]), .ie_o(ie_q[c]), .sts_o(sts_q[c]), .irq_o(irq_o[c])
    );
  end

  mtimer_snap #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(wr && region == RG_SNAP && bus_wdata_i[0]),
    .cnt_i(cnt_q[0]), .snap_o(snap_q), .busy_o(busy)
  );

  always_comb begin
    unique case (region)
      RG_MATCH: bus_rdata_o = match_q[ch][cmp];
      RG_PRE:   bus_rdata_o = pre_q[ch];
      RG_SEL:   bus_rdata_o = CW'(sel_q[ch]);
      RG_STS:   bus_rdata_o = CW'(sts_q[ch]);
      RG_IE:    bus_rdata_o = CW'(ie_q[ch]);
      RG_RUN:   bus_rdata_o = CW'(run_q);
      RG_SNAP:  bus_rdata_o = snap_q;
      RG_BUSY:  bus_rdata_o = CW'(busy);
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int NUM_CH  = 3,
  parameter int NUM_CMP = 3,
  parameter int CW      = 32
) (
  input logic                                      clk_i,
  input logic                                      rst_ni,
  input logic [NUM_CH-1:0]                         run,
  input logic [NUM_CH-1:0][CW-1:0]                 cnt,
  input logic [NUM_CH-1:0][NUM_CMP-1:0][CW-1:0]    match,
  input logic [NUM_CH-1:0][CW-1:0]                 pre,
  input logic [NUM_CH-1:0][NUM_CMP-1:0]            sel,
  input logic [NUM_CH-1:0][NUM_CMP-1:0]            ie,
  input logic [NUM_CH-1:0][NUM_CMP-1:0]            sts,
  input logic [NUM_CH-1:0][NUM_CMP-1:0]            clr,
  input logic [CW-1:0]                             snap,
  input logic                                      busy,
  input logic [NUM_CH-1:0]                         irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run[c] |=> $stable(cnt[c]));
    assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run[c] && sel[c] == '0) |=> cnt[c] == CW'($past(cnt[c]) + 1'b1));
    assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run[c] && sel[c][0] && cnt[c] == match[c][0]) |=> cnt[c] == $past(pre[c]));
    assert_irq_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ie[c] == '0) |-> !irq[c]);
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_k
      assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts[c][k] && !clr[c][k]) |=> sts[c][k]);
    end
  end

  assert_snap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> $stable(snap));
endmodule

bind mtimer_top mtimer_chk #(.NUM_CH(NUM_CH), .NUM_CMP(NUM_CMP), .CW(CW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run_q), .cnt(cnt_q), .match(match_q),
  .pre(pre_q), .sel(sel_q), .ie(ie_q), .sts(sts_q), .clr(clr), .snap(snap_q),
  .busy(busy), .irq(irq_o)
);

// File: tb/mtimer_top_tb_top.sv
module mtimer_top_tb_top;
  localparam int A_PRE = 9, A_SEL = 12, A_STS = 15, A_IE = 18, A_ICLR = 21;
  localparam int A_RUN = 24, A_SNAP = 25, A_BUSY = 26;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int nchk = 0, nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mtimer_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [31:0] m_cnt [3];
  logic [31:0] m_match [3][3];
  logic [31:0] m_pre [3];
  logic [2:0]  m_sel [3], m_ie [3], m_sts [3];
  logic [2:0]  m_run;
  logic [31:0] m_snap;
  int          m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_cnt[c] = 0; m_pre[c] = 0; m_sel[c] = 0; m_ie[c] = 0; m_sts[c] = 0;
        for (int k = 0; k < 3; k++) m_match[c][k] = '1;
      end
      m_run = 0; m_snap = 0; m_left = 0;
    end else begin
      logic [31:0] c0;
      logic [2:0]  hit, clrm;
      bit          w;
      w  = req && we;
      c0 = m_cnt[0];
      for (int c = 0; c < 3; c++) begin
        for (int k = 0; k < 3; k++) hit[k] = m_run[c] && (m_cnt[c] == m_match[c][k]);
        clrm = (w && (addr == 6'(A_STS + c) || addr == 6'(A_ICLR + c))) ? wdata[2:0] : 3'b0;
        m_sts[c] = (m_sts[c] & ~clrm) | hit;
        if (m_run[c]) m_cnt[c] = ((hit & m_sel[c]) != 0) ? m_pre[c] : m_cnt[c] + 1;
      end
      if (m_left > 0) begin
        if (m_left == 1) m_snap = c0;
        m_left--;
      end else if (w && addr == 6'(A_SNAP) && wdata[0]) m_left = 2;
      if (w) begin
        if (addr < 9) m_match[addr/3][addr%3] = wdata;
        else if (addr < A_SEL) m_pre[addr-A_PRE] = wdata;
        else if (addr < A_STS) m_sel[addr-A_SEL] = wdata[2:0];
        else if (addr >= A_IE && addr < A_ICLR) m_ie[addr-A_IE] = wdata[2:0];
        else if (addr == A_RUN) m_run = wdata[2:0];
      end
    end
  end

  function automatic logic [31:0] exp_rd(input int a);
    if (a < 9)       return m_match[a/3][a%3];
    if (a < A_SEL)   return m_pre[a-A_PRE];
    if (a < A_STS)   return 32'(m_sel[a-A_SEL]);
    if (a < A_IE)    return 32'(m_sts[a-A_STS]);
    if (a < A_ICLR)  return 32'(m_ie[a-A_IE]);
    if (a < A_RUN)   return 0;
    if (a == A_RUN)  return 32'(m_run);
    if (a == A_SNAP) return m_snap;
    if (a == A_BUSY) return 32'(m_left != 0);
    return 0;
  endfunction

  function automatic logic [2:0] exp_irq();
    logic [2:0] r;
    for (int c = 0; c < 3; c++) r[c] = |(m_sts[c] & m_ie[c]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = 6'(a); wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = 6'(a);
    #1 d = rdata; req = 0;
  endtask

  task automatic rd_model(input string tag, input int a);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp_rd(a));
    chk(tag, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic take_snap(output logic [31:0] d);
    wr(A_SNAP, 1);
    repeat (3) @(negedge clk);
    rd(A_SNAP, d);
    chk("R9 snapshot vs model", d, m_snap);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog act=timeout exp=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, s1, s2;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, d);      chk("R1 compare reset", d, 32'hFFFF_FFFF);
    rd(A_PRE, d);  chk("R1 preload reset", d, 0);
    rd(A_STS, d);  chk("R1 status reset", d, 0);
    rd(A_BUSY, d); chk("R1 busy reset", d, 0);
    rd(A_SNAP, d); chk("R1 snapshot reset", d, 0);
    chk("R1 irq reset", 32'(irq), 0);

    // R3 compare indexing
    wr(4, 32'h1234_5678);
    rd(4, d); chk("R3 written compare", d, 32'h1234_5678);
    rd(3, d); chk("R3 neighbour untouched", d, 32'hFFFF_FFFF);
    rd(7, d); chk("R3 other channel untouched", d, 32'hFFFF_FFFF);

    // R2 enable of ch0 and hold
    wr(A_RUN, 1);
    repeat (10) @(negedge clk);
    take_snap(d);
    wr(A_RUN, 0);
    take_snap(s1);
    repeat (7) @(negedge clk);
    take_snap(s2);
    chk("R2 count holds while disabled", s2, s1);

    // R4 reload from comparator 0
    wr(0, 20); wr(A_PRE, 5); wr(A_SEL, 1); wr(A_RUN, 1);
    repeat (60) @(negedge clk);
    take_snap(d);
    chk("R4 count inside reload window", 32'(d >= 5 && d <= 20), 1);
    wr(A_RUN, 0);
    take_snap(s1);

    // R5 wrap through all ones
    wr(2, s1); wr(A_PRE, 32'hFFFF_FFF0); wr(A_SEL, 4); wr(A_RUN, 1);
    wr(A_SEL, 0);
    repeat (25) @(negedge clk);
    take_snap(d);
    chk("R5 wrapped to small value", 32'(d < 32'h100), 1);
    rd_model("R6 status ch0", A_STS);
    wr(A_RUN, 0);
    wr(A_STS, 7);
    rd(A_STS, d); chk("R6 write-one clears", d, 0);

    // R7/R8 interrupt on ch2, ch1 idle
    wr(6, 3); wr(A_IE + 2, 1); wr(A_RUN, 4);
    repeat (8) @(negedge clk);
    chk("R8 irq raised", 32'(irq[2]), 1);
    rd(A_STS + 2, d); chk("R6 sticky ch2 bit0", d, 1);
    rd(A_STS + 1, d); chk("R2 idle channel no status", d, 0);
    wr(A_IE + 2, 0);
    chk("R8 irq masked", 32'(irq[2]), 0);
    wr(A_IE + 2, 1);
    chk("R8 irq unmasked", 32'(irq[2]), 1);
    wr(A_STS + 2, 0);
    rd(A_STS + 2, d); chk("R6 write zero keeps bit", d, 1);
    wr(A_ICLR + 2, 1);
    rd(A_STS + 2, d); chk("R7 clear register clears", d, 0);
    chk("R7 irq dropped", 32'(irq[2]), 0);
    rd(A_ICLR + 2, d); chk("R7 clear reads zero", d, 0);

    // R9/R10 capture handshake
    wr(A_RUN, 1);
    rd(A_SNAP, s1);
    wr(A_SNAP, 0);
    rd(A_BUSY, d); chk("R10 zero write no busy", d, 0);
    rd(A_SNAP, d); chk("R10 zero write no capture", d, s1);
    wr(A_SNAP, 1);
    wr(A_SNAP, 1);
    rd(A_BUSY, d); chk("R10 request while busy ignored", d, 0);
    wr(A_SNAP, 1);
    rd(A_BUSY, d); chk("R9 busy during capture", d, 1);
    rd(A_BUSY, d); chk("R9 busy ends", d, 0);
    rd(A_SNAP, d); chk("R9 capture value", d, m_snap);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int op, a;
      op = int'($urandom % 4);
      a  = int'($urandom % 27);
      case (op)
        0: wr(a, (a < A_SEL) ? 32'($urandom % 48) : $urandom);
        1: rd_model("R2 R4 R6 random read", a);
        2: wr(A_SNAP, 1);
        default: repeat (int'($urandom % 5)) @(negedge clk);
      endcase
    end
    repeat (4) @(negedge clk);
    for (int a = 0; a < 27; a++) rd_model("R3 R8 final sweep", a);

    done = 1;
    finish_run();
  end
endmodule